// File: doc/BRIEF.md
# Double-Buffered Receive Packet Buffer

This block stores received packets for a single USB-style receive endpoint. A link layer writes each packet as a stream of bytes with start and end markers. The block commits the packet to a slot only when it has arrived whole and within the size limit. A configuration bit chooses between one slot and two slots. With two slots, the next packet can arrive while the previous one is still being drained.

The read side shows the oldest committed packet. It gives that packet's byte count and the byte at the current read position. A read strobe moves the position forward. Reading the final byte frees the slot. A packet-ready flag and a DMA request line tell the consumer that data is waiting. A flush pulse discards the oldest packet without reading it. When every enabled slot is occupied, the write-ready output goes low so that the link layer can refuse (NAK) the next packet.

Top module: `rx_pkt_store`

## Requirements
- R1: After reset, `pkt_ready` and `dma_req` are 0, `wr_ready` is 1 and `wr_ovr` is 0.
- R2: With `cfg_dual`=0, at most one packet is held. After one commit, `wr_ready` is 0. A packet that starts while no slot is free is ignored completely and commits nothing.
- R3: With `cfg_dual`=1, up to two packets are held and `wr_ready` is 0 only when both are stored. A second packet can be written and committed while the first is still being read.
- R4: `pkt_ready` is 1 exactly when at least one packet is stored. It rises in the cycle after the clock edge that accepts the beat with `wr_eop` set.
- R5: `dma_req` is 1 exactly when `pkt_ready` is 1 and `cfg_dma_en` is 1.
- R6: `rd_count` shows the byte count of the oldest stored packet, and `rd_data` shows the byte at the current read position, starting at the first byte. An `rd_en` edge while `pkt_ready`=1 moves to the next byte. An `rd_en` edge on the last byte frees that packet.
- R7: A `flush` pulse discards only the oldest stored packet. With two packets stored, two flush pulses are needed to empty the block. A flush while the block is empty has no effect.
- R8: A `wr_abort` pulse during a packet discards that packet, and no slot is committed. The abort takes priority over a beat in the same cycle.
- R9: The size limit is `cfg_max_pkt`. If `cfg_max_pkt` is 0 or greater than SLOT_BYTES, the limit is SLOT_BYTES. A packet with more bytes than the limit is dropped. `wr_ovr` is 1 for exactly one cycle, the cycle after the first excess beat.
- R10: Stored packets are read out in the order in which they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dual | input | 1 | 1 selects two packet slots, 0 selects one |
| cfg_dma_en | input | 1 | Enables the DMA request output |
| cfg_max_pkt | input | CNT_W | Maximum packet size in bytes |
| wr_valid | input | 1 | A write byte is present |
| wr_sop | input | 1 | The byte is the first of a packet |
| wr_eop | input | 1 | The byte is the last of a packet |
| wr_abort | input | 1 | Discards the packet in progress |
| wr_data | input | DATA_W | Write byte |
| wr_ready | output | 1 | A free slot exists for a new packet |
| wr_ovr | output | 1 | One-cycle pulse when a packet exceeds the limit |
| rd_en | input | 1 | Advances the read position |
| flush | input | 1 | Discards the oldest stored packet |
| rd_data | output | DATA_W | Byte at the read position of the oldest packet |
| rd_count | output | CNT_W | Byte count of the oldest packet |
| pkt_ready | output | 1 | At least one packet is stored |
| dma_req | output | 1 | DMA request |

## Verification
The bench first runs a set of directed cases, then a random stream of sends, aborts, oversized packets, reads and flushes in both modes, and compares every output against a queue model.

The directed cases target the places where a wrong design would still look plausible:
- **Double flush.** A flush that emptied the whole buffer would lose the second packet in the two-flush case.
- **Ignored packet in single-slot mode.** A design that accepted this packet would overwrite the packet being held.
- **Write during read.** A design that committed into the head slot would corrupt bytes still being read out.
- **Limit-sized packet.** A packet exactly at the limit must be kept, and one byte more must be dropped with a single `wr_ovr` pulse. An off-by-one in the comparison would flip either outcome.

// File: rtl/rxps_pkg.sv
package rxps_pkg;
   localparam int NSLOT = 2;
   typedef enum logic [1:0] {WS_IDLE, WS_RECV, WS_DROP} wr_state_e;
endpackage

// File: rtl/rxps_slot_ctrl.sv
module rxps_slot_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic dual,
   input  logic commit,
   input  logic pop,
   output logic space,
   output logic nonempty,
   output logic wr_ptr,
   output logic hd_ptr
);
   logic [1:0] occ;
   logic [1:0] cap;

   assign cap      = dual ? 2'd2 : 2'd1;
   assign space    = occ < cap;
   assign nonempty = occ != 2'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ    <= 2'd0;
         wr_ptr <= 1'b0;
         hd_ptr <= 1'b0;
      end else begin
         if (commit) wr_ptr <= dual ? ~wr_ptr : 1'b0;
         if (pop)    hd_ptr <= dual ? ~hd_ptr : 1'b0;
         case ({commit, pop})
            2'b10:   occ <= occ + 2'd1;
            2'b01:   occ <= occ - 2'd1;
            default: occ <= occ;
         endcase
      end
   end

   p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> occ != 2'd0);
   p_commit_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (occ < cap) || pop);
endmodule

// File: rtl/rxps_wr_fsm.sv
module rxps_wr_fsm
   import rxps_pkg::*;
#(
   parameter int SLOT_BYTES = 512,
   parameter int CNT_W = $clog2(SLOT_BYTES + 1),
   parameter int AW = $clog2(SLOT_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             wr_sop,
   input  logic             wr_eop,
   input  logic             wr_abort,
   input  logic             space,
   input  logic [CNT_W-1:0] limit,
   output logic             beat_we,
   output logic [AW-1:0]    beat_addr,
   output logic             commit,
   output logic [CNT_W-1:0] commit_cnt,
   output logic             wr_ovr
);
   wr_state_e        st_q, st_d;
   logic [CNT_W-1:0] idx_q, idx_d;
   logic             ovr_hit;

   always_comb begin
      st_d       = st_q;
      idx_d      = idx_q;
      beat_we    = 1'b0;
      beat_addr  = AW'(idx_q);
      commit     = 1'b0;
      commit_cnt = idx_q + CNT_W'(1);
      ovr_hit    = 1'b0;
      if (wr_abort) begin
         st_d  = WS_IDLE;
         idx_d = '0;
      end else if (wr_valid) begin
         if (wr_sop) begin
            idx_d = '0;
            if (space) begin
               beat_we    = 1'b1;
               beat_addr  = '0;
               commit     = wr_eop;
               commit_cnt = CNT_W'(1);
               st_d       = wr_eop ? WS_IDLE : WS_RECV;
               idx_d      = CNT_W'(1);
            end else begin
               st_d = wr_eop ? WS_IDLE : WS_DROP;
            end
         end else if (st_q == WS_RECV) begin
            if (idx_q >= limit) begin
               ovr_hit = 1'b1;
               st_d    = wr_eop ? WS_IDLE : WS_DROP;
            end else begin
               beat_we = 1'b1;
               commit  = wr_eop;
               st_d    = wr_eop ? WS_IDLE : WS_RECV;
               idx_d   = idx_q + CNT_W'(1);
            end
         end else if (st_q == WS_DROP && wr_eop) begin
            st_d = WS_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WS_IDLE;
         idx_q  <= '0;
         wr_ovr <= 1'b0;
      end else begin
         st_q   <= st_d;
         idx_q  <= idx_d;
         wr_ovr <= ovr_hit;
      end
   end

   p_abort_nocommit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |-> !commit && !beat_we);
   p_ovr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_hit |-> !commit);
   p_ovr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ovr |=> !wr_ovr);
endmodule

// File: rtl/rxps_store.sv
module rxps_store
   import rxps_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SLOT_BYTES = 512,
   parameter int CNT_W = $clog2(SLOT_BYTES + 1),
   parameter int AW = $clog2(SLOT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wslot,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              rslot,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  rcount
);
   logic [DATA_W-1:0] slot_rd  [NSLOT];
   logic [CNT_W-1:0]  slot_cnt [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [DATA_W-1:0] mem [SLOT_BYTES];
      logic [CNT_W-1:0]  cnt_q;

      always_ff @(posedge clk) begin
         if (we && wslot == 1'(s)) mem[waddr] <= wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt_q <= '0;
         else if (cnt_we && wslot == 1'(s)) cnt_q <= cnt_val;
      end

      assign slot_rd[s]  = mem[raddr];
      assign slot_cnt[s] = cnt_q;
   end

   assign rdata  = slot_rd[rslot];
   assign rcount = slot_cnt[rslot];
endmodule

// File: rtl/rx_pkt_store.sv
module rx_pkt_store
   import rxps_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SLOT_BYTES = 512,
   localparam int CNT_W = $clog2(SLOT_BYTES + 1),
   localparam int AW = $clog2(SLOT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dual,
   input  logic              cfg_dma_en,
   input  logic [CNT_W-1:0]  cfg_max_pkt,
   input  logic              wr_valid,
   input  logic              wr_sop,
   input  logic              wr_eop,
   input  logic              wr_abort,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              wr_ovr,
   input  logic              rd_en,
   input  logic              flush,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  rd_count,
   output logic              pkt_ready,
   output logic              dma_req
);
   if (SLOT_BYTES < 2) begin : g_bad_depth
      $error("rx_pkt_store: SLOT_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rx_pkt_store: DATA_W must be positive");
   end

   logic             space, nonempty, wr_ptr, hd_ptr;
   logic             beat_we, commit, pop, last_byte;
   logic [AW-1:0]    beat_addr, rd_idx;
   logic [CNT_W-1:0] commit_cnt, limit;

   assign limit = (cfg_max_pkt == '0 || cfg_max_pkt > CNT_W'(SLOT_BYTES))
                  ? CNT_W'(SLOT_BYTES) : cfg_max_pkt;

   rxps_wr_fsm #(.SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W), .AW(AW)) u_wr (
      .clk, .rst_n, .wr_valid, .wr_sop, .wr_eop, .wr_abort,
      .space, .limit, .beat_we, .beat_addr, .commit, .commit_cnt, .wr_ovr
   );

   rxps_slot_ctrl u_ctrl (
      .clk, .rst_n, .dual(cfg_dual), .commit, .pop,
      .space, .nonempty, .wr_ptr, .hd_ptr
   );

   rxps_store #(.DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W), .AW(AW)) u_store (
      .clk, .rst_n, .we(beat_we), .wslot(wr_ptr), .waddr(beat_addr), .wdata(wr_data),
      .cnt_we(commit), .cnt_val(commit_cnt), .rslot(hd_ptr), .raddr(rd_idx),
      .rdata(rd_data), .rcount(rd_count)
   );

   assign last_byte = CNT_W'(rd_idx) == rd_count - CNT_W'(1);
   assign pop       = nonempty && (flush || (rd_en && last_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rd_idx <= '0;
      else if (pop)                   rd_idx <= '0;
      else if (rd_en && nonempty)     rd_idx <= rd_idx + AW'(1);
   end

   assign wr_ready  = space;
   assign pkt_ready = nonempty;
   assign dma_req   = nonempty && cfg_dma_en;

   p_ready_after_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> pkt_ready);
   p_dma_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> cfg_dma_en);
   p_rd_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> CNT_W'(rd_idx) < rd_count);
endmodule

// File: tb/tb_rx_pkt_store.sv
module tb_rx_pkt_store;
   localparam int DATA_W = 8;
   localparam int SLOT_BYTES = 512;
   localparam int CNT_W = $clog2(SLOT_BYTES + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_dual = 1'b0, cfg_dma_en = 1'b0;
   logic [CNT_W-1:0] cfg_max_pkt = CNT_W'(16);
   logic wr_valid = 0, wr_sop = 0, wr_eop = 0, wr_abort = 0, rd_en = 0, flush = 0;
   logic [DATA_W-1:0] wr_data = '0;
   logic wr_ready, wr_ovr, pkt_ready, dma_req;
   logic [DATA_W-1:0] rd_data;
   logic [CNT_W-1:0]  rd_count;

   int checks = 0, errors = 0, cycles = 0;
   int exp_len[$];
   int exp_bytes[$];

   rx_pkt_store #(.DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES)) dut (.*);

   always #5 clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cap();
      return cfg_dual ? 2 : 1;
   endfunction

   function automatic int lim();
      return (cfg_max_pkt == 0 || int'(cfg_max_pkt) > SLOT_BYTES) ? SLOT_BYTES : int'(cfg_max_pkt);
   endfunction

   task automatic check_state(input string tag);
      check({tag, " R4 pkt_ready"}, int'(pkt_ready), int'(exp_len.size() != 0));
      check({tag, " R2/R3 wr_ready"}, int'(wr_ready), int'(exp_len.size() < cap()));
      check({tag, " R5 dma_req"}, int'(dma_req), int'(exp_len.size() != 0 && cfg_dma_en));
      if (exp_len.size() != 0) check({tag, " R6 rd_count"}, int'(rd_count), exp_len[0]);
   endtask

   // abort_at < 0: no abort
   task automatic send_pkt(input int len, input int abort_at);
      int  bytes[$];
      int  ovr_seen = 0;
      bit  room = exp_len.size() < cap();
      bit  aborted = 0;
      for (int k = 0; k < len; k++) begin
         if (k == abort_at) begin
            wr_valid = 0; wr_abort = 1; aborted = 1;
            @(negedge clk);
            if (wr_ovr) ovr_seen++;
            break;
         end
         wr_valid = 1; wr_sop = (k == 0); wr_eop = (k == len - 1);
         wr_data  = DATA_W'($urandom);
         bytes.push_back(int'(wr_data));
         @(negedge clk);
         if (wr_ovr) ovr_seen++;
      end
      wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_abort = 0;
      if (!aborted) begin
         check("R9 wr_ovr pulses", ovr_seen, int'(room && len > lim()));
         if (room && len <= lim()) begin
            exp_len.push_back(len);
            foreach (bytes[i]) exp_bytes.push_back(bytes[i]);
         end
      end else begin
         check("R8 no ovr on abort", ovr_seen, 0);
      end
   endtask

   task automatic read_pkt();
      int len = exp_len[0];
      check("R6 count at read", int'(rd_count), len);
      for (int i = 0; i < len; i++) begin
         check("R6/R10 rd_data", int'(rd_data), exp_bytes.pop_front());
         rd_en = 1;
         @(negedge clk);
         rd_en = 0;
      end
      void'(exp_len.pop_front());
   endtask

   task automatic do_flush();
      flush = 1;
      @(negedge clk);
      flush = 0;
      if (exp_len.size() != 0) begin
         for (int i = 0; i < exp_len[0]; i++) void'(exp_bytes.pop_front());
         void'(exp_len.pop_front());
      end
   endtask

   task automatic drain();
      while (exp_len.size() != 0) read_pkt();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog timeout R1-related run hung actual=%0d expected=0", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 pkt_ready", int'(pkt_ready), 0);
      check("R1 dma_req", int'(dma_req), 0);
      check("R1 wr_ready", int'(wr_ready), 1);
      check("R1 wr_ovr", int'(wr_ovr), 0);

      // R2 single slot: second packet ignored
      cfg_dual = 0; cfg_dma_en = 1;
      send_pkt(5, -1);
      check_state("R2 one stored");
      check("R2 wr_ready low", int'(wr_ready), 0);
      send_pkt(7, -1);
      check_state("R2 second ignored");
      read_pkt();
      check_state("R2 empty after read");
      check("R2 nothing left", int'(pkt_ready), 0);

      // R3 dual slot: write while reading
      cfg_dual = 1;
      send_pkt(8, -1);
      fork
         send_pkt(6, -1);
         read_pkt();
      join
      check_state("R3 overlap");
      send_pkt(4, -1);
      check("R3 full", int'(wr_ready), 0);
      send_pkt(3, -1);
      check_state("R3 third ignored");

      // R7 two flushes needed
      do_flush();
      check_state("R7 first flush");
      check("R7 one left", int'(pkt_ready), 1);
      do_flush();
      check_state("R7 second flush");
      do_flush();
      check_state("R7 flush empty");

      // R8 abort
      send_pkt(10, 4);
      check_state("R8 after abort");
      check("R8 nothing committed", int'(pkt_ready), 0);

      // R9 limit boundary
      send_pkt(16, -1);
      check_state("R9 at limit kept");
      read_pkt();
      send_pkt(17, -1);
      check_state("R9 over limit dropped");
      cfg_max_pkt = '0;
      send_pkt(40, -1);
      check_state("R9 zero limit means slot size");
      read_pkt();
      cfg_max_pkt = CNT_W'(16);

      // R5 dma disabled
      cfg_dma_en = 0;
      send_pkt(2, -1);
      check_state("R5 dma off");
      drain();

      // random phase
      for (int it = 0; it < 150; it++) begin
         int op = int'($urandom_range(0, 9));
         cfg_dma_en = $urandom_range(0, 1) != 0;
         if (exp_len.size() == 0 && op == 9) cfg_dual = $urandom_range(0, 1) != 0;
         if (op < 4)       send_pkt(int'($urandom_range(1, 14)), -1);
         else if (op == 4) send_pkt(int'($urandom_range(17, 22)), -1);
         else if (op == 5) send_pkt(12, int'($urandom_range(1, 10)));
         else if (op < 8)  begin if (exp_len.size() != 0) read_pkt(); end
         else              do_flush();
         @(negedge clk);
         check_state("R10 random");
      end
      drain();
      check_state("final");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule